// File: doc/BRIEF.md
# Interrupt latch and trap vectoring unit

This unit sits beside the control sequencer of a multi-cycle processor. It catches a rising edge on an external interrupt request and holds it as a pending flag until the request is serviced. The pending flag is combined with a one-bit enable to form the interrupt signal seen by the sequencer. The unit also accepts two synchronous faults from the sequencer: an undefined opcode found during decode, and an arithmetic overflow found during execute.

When the sequencer is in its fetch step and the interrupt signal is high, or when a fault is reported, the unit tells the sequencer to leave its normal path. It then runs two service steps. In the save step it writes the address of the instruction to resume into a return-address register. In the jump step it loads the program counter with the trap vector, drops the enable and, for an interrupt, clears the pending flag. A return-from-handler instruction, flagged by the sequencer during decode, reloads the program counter from the return-address register and sets the enable again. Nested service and any cause register are not part of this unit.

Top module: `intr_vector_unit`

## Requirements
- R1: While rst_ni is low, state_o is 0, int_o, divert_o and pc_load_o are 0, eint_o is 1 and epc_o is 0.
- R2: A rising edge of irq_i sets the pending flag at the clock edge that first samples irq_i high. A level that stays high does not set it again after it has been cleared.
- R3: int_o is 1 exactly when the pending flag is set and eint_o is 1. A pending request seen while eint_o is 0 stays pending and raises int_o once the enable returns.
- R4: The state encoding is 0 for run, 1 for save and 2 for jump. In run, divert_o is 1 in the same cycle as ovf_i, undef_i, or fetch_i together with int_o. The state is then 1 in the next cycle, 2 in the one after, and 0 after that.
- R5: In state 2, pc_load_o is 1. After that cycle eint_o is 0, and after an interrupt entry the pending flag is cleared.
- R6: epc_o holds the value pc_i had in the cycle divert_o was 1, starting with the jump cycle.
- R7: In state 2, pc_value_o is 0xC0000020 after an overflow and 0xC0000000 after an undefined opcode or an interrupt. Overflow takes priority over undefined opcode, and both take priority over an interrupt. A fault entry leaves the pending flag unchanged.
- R8: In run with no divert, iret_i makes pc_load_o 1 with pc_value_o equal to epc_o in the same cycle, and eint_o is 1 from the next cycle.
- R9: divert_o is 0 in states 1 and 2, and when int_o is high without fetch_i. In state 1 pc_load_o is 0. Fault, fetch and iret inputs given in states 1 and 2 are dropped.
- R10: An irq_i rising edge in the same cycle that a jump clears the pending flag leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | External interrupt request, level |
| fetch_i | input | 1 | Sequencer is in its fetch step |
| pc_i | input | 32 | Address of the instruction in progress |
| undef_i | input | 1 | Undefined opcode found at decode |
| ovf_i | input | 1 | Arithmetic overflow found at execute |
| iret_i | input | 1 | Return-from-handler decoded |
| int_o | output | 1 | Pending request gated by the enable |
| eint_o | output | 1 | Interrupt enable |
| divert_o | output | 1 | Sequencer goes to the save step next |
| state_o | output | 2 | Service state: 0 run, 1 save, 2 jump |
| pc_load_o | output | 1 | Load the program counter this cycle |
| pc_value_o | output | 32 | Value to load into the program counter |
| epc_o | output | 32 | Saved return address |

## Verification
divert_o and an iret load are combinational, so they are checked in the cycle their inputs are driven. The state steps forward one edge per step, so the vector and return-address outputs are checked two edges after a divert. A new pending flag is checked one edge after the irq_i edge, and eint_o is checked one edge after a jump or iret. Inputs change just after the falling edge, and outputs are sampled one time unit later. A cycle model in the bench moves at each rising edge, so every comparison falls in the cycle the requirement names.

// File: rtl/intr_vector_pkg.sv
package intr_vector_pkg;
  localparam int unsigned XLEN = 32;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_SAVE = 2'd1,
    ST_JUMP = 2'd2
  } svc_state_e;
endpackage

// File: rtl/irq_latch.sv
module irq_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_i,
  input  logic clr_i,
  output logic pend_o
);
  logic irq_d_q;
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_d_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      irq_d_q <= irq_i;
      // a fresh edge wins over a clear in the same cycle
      if (irq_i && !irq_d_q) pend_q <= 1'b1;
      else if (clr_i)        pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/int_gate.sv
module int_gate #(
  parameter bit EINT_RST = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_i,
  input  logic set_i,
  input  logic clr_i,
  output logic eint_o,
  output logic int_o
);
  logic eint_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    eint_q <= EINT_RST;
    else if (clr_i) eint_q <= 1'b0;
    else if (set_i) eint_q <= 1'b1;
  end

  assign eint_o = eint_q;
  assign int_o  = pend_i & eint_q;
endmodule

// File: rtl/svc_fsm.sv
module svc_fsm
  import intr_vector_pkg::*;
#(
  parameter int unsigned     W         = XLEN,
  parameter logic [W-1:0]    VEC_INT   = 'hC000_0000,
  parameter logic [W-1:0]    VEC_UNDEF = 'hC000_0000,
  parameter logic [W-1:0]    VEC_OVF   = 'hC000_0020
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fetch_i,
  input  logic         int_i,
  input  logic         undef_i,
  input  logic         ovf_i,
  input  logic         iret_i,
  output svc_state_e   state_o,
  output logic         divert_o,
  output logic         commit_o,
  output logic         jump_o,
  output logic         clr_irq_o,
  output logic         eint_set_o,
  output logic         pc_load_o,
  output logic [W-1:0] vec_o
);
  svc_state_e   state_q, state_d;
  logic [W-1:0] vec_q, vec_d;
  logic         is_int_q, is_int_d;
  logic         run, take_ovf, take_undef, take_int, trap;

  always_comb begin
    run        = (state_q == ST_RUN);
    take_ovf   = ovf_i;
    take_undef = undef_i & ~ovf_i;
    take_int   = fetch_i & int_i & ~ovf_i & ~undef_i;
    trap       = take_ovf | take_undef | take_int;

    divert_o   = run & trap;
    eint_set_o = run & ~trap & iret_i;
    commit_o   = (state_q == ST_SAVE);
    jump_o     = (state_q == ST_JUMP);
    clr_irq_o  = jump_o & is_int_q;
    pc_load_o  = jump_o | eint_set_o;

    state_d  = state_q;
    vec_d    = vec_q;
    is_int_d = is_int_q;
    unique case (state_q)
      ST_RUN: if (trap) begin
        state_d  = ST_SAVE;
        is_int_d = take_int;
        vec_d    = take_ovf ? VEC_OVF : (take_undef ? VEC_UNDEF : VEC_INT);
      end
      ST_SAVE: state_d = ST_JUMP;
      ST_JUMP: state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_RUN;
      vec_q    <= '0;
      is_int_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      vec_q    <= vec_d;
      is_int_q <= is_int_d;
    end
  end

  assign state_o = state_q;
  assign vec_o   = vec_q;
endmodule

// File: rtl/pc_save.sv
module pc_save #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic         commit_i,
  input  logic [W-1:0] pc_i,
  output logic [W-1:0] epc_o
);
  logic [W-1:0] hold_q, epc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      epc_q  <= '0;
    end else begin
      if (cap_i)    hold_q <= pc_i;
      if (commit_i) epc_q  <= hold_q;
    end
  end

  assign epc_o = epc_q;
endmodule

// File: rtl/intr_vector_unit.sv
module intr_vector_unit
  import intr_vector_pkg::*;
#(
  parameter int unsigned  W         = XLEN,
  parameter logic [W-1:0] VEC_INT   = 'hC000_0000,
  parameter logic [W-1:0] VEC_UNDEF = 'hC000_0000,
  parameter logic [W-1:0] VEC_OVF   = 'hC000_0020,
  parameter bit           EINT_RST  = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         irq_i,
  input  logic         fetch_i,
  input  logic [W-1:0] pc_i,
  input  logic         undef_i,
  input  logic         ovf_i,
  input  logic         iret_i,
  output logic         int_o,
  output logic         eint_o,
  output logic         divert_o,
  output logic [1:0]   state_o,
  output logic         pc_load_o,
  output logic [W-1:0] pc_value_o,
  output logic [W-1:0] epc_o
);
  logic       pend, clr_irq, eint_set, commit, jump;
  svc_state_e state;
  logic [W-1:0] vec;

  irq_latch u_latch (
    .clk_i, .rst_ni, .irq_i, .clr_i(clr_irq), .pend_o(pend)
  );

  int_gate #(.EINT_RST(EINT_RST)) u_gate (
    .clk_i, .rst_ni, .pend_i(pend), .set_i(eint_set), .clr_i(jump),
    .eint_o, .int_o
  );

  svc_fsm #(.W(W), .VEC_INT(VEC_INT), .VEC_UNDEF(VEC_UNDEF), .VEC_OVF(VEC_OVF)) u_fsm (
    .clk_i, .rst_ni, .fetch_i, .int_i(int_o), .undef_i, .ovf_i, .iret_i,
    .state_o(state), .divert_o, .commit_o(commit), .jump_o(jump),
    .clr_irq_o(clr_irq), .eint_set_o(eint_set), .pc_load_o, .vec_o(vec)
  );

  pc_save #(.W(W)) u_save (
    .clk_i, .rst_ni, .cap_i(divert_o), .commit_i(commit), .pc_i, .epc_o
  );

  assign state_o    = state;
  assign pc_value_o = jump ? vec : epc_o;
endmodule

// File: rtl/intr_vector_chk.sv
module intr_vector_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] pc_i,
  input logic         iret_i,
  input logic         int_o,
  input logic         eint_o,
  input logic         divert_o,
  input logic [1:0]   state_o,
  input logic         pc_load_o,
  input logic [W-1:0] epc_o
);
  // R4
  divert_to_save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    divert_o |=> state_o == 2'd1);
  // R4
  save_to_jump_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd1 |=> state_o == 2'd2);
  // R5
  jump_loads_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd2 |-> pc_load_o);
  // R5
  jump_drops_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd2 |=> !eint_o);
  // R6
  epc_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd2 |-> epc_o == $past(pc_i, 2));
  // R8
  iret_enables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0 && iret_i && !divert_o) |=> eint_o);
  // R9
  no_divert_in_svc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'd0 |-> !divert_o);
  // R3
  int_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> eint_o);
endmodule

bind intr_vector_unit intr_vector_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pc_i(pc_i), .iret_i(iret_i),
  .int_o(int_o), .eint_o(eint_o), .divert_o(divert_o), .state_o(state_o),
  .pc_load_o(pc_load_o), .epc_o(epc_o)
);

// File: tb/intr_vector_unit_tb.sv
module intr_vector_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] V_INT = 32'hC000_0000;
  localparam logic [31:0] V_OVF = 32'hC000_0020;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic irq = 0, fetch = 0, undef = 0, ovf = 0, iret = 0;
  logic [31:0] pc = '0;
  logic int_o, eint_o, divert_o, pc_load_o;
  logic [1:0] state_o;
  logic [31:0] pc_value_o, epc_o;

  int total = 0, bad = 0;
  bit done = 0;

  // model state
  logic [1:0] m_state = 0;
  logic m_pend = 0, m_eint = 1, m_irq_d = 0, m_isint = 0;
  logic [31:0] m_epc = 0, m_hold = 0, m_vec = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_vector_unit u_dut (
    .clk_i(clk), .rst_ni, .irq_i(irq), .fetch_i(fetch), .pc_i(pc),
    .undef_i(undef), .ovf_i(ovf), .iret_i(iret), .int_o, .eint_o,
    .divert_o, .state_o, .pc_load_o, .pc_value_o, .epc_o
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_int();
    return m_pend & m_eint;
  endfunction

  function automatic logic exp_trap();
    return ovf | undef | (fetch & exp_int());
  endfunction

  task automatic step(logic i_irq, logic i_fetch, logic i_undef, logic i_ovf,
                      logic i_iret, logic [31:0] i_pc);
    logic trap, run, load;
    @(negedge clk);
    irq = i_irq; fetch = i_fetch; undef = i_undef; ovf = i_ovf;
    iret = i_iret; pc = i_pc;
    #1;
    run  = (m_state == 2'd0);
    trap = run & exp_trap();
    load = (m_state == 2'd2) | (run & !trap & iret);
    chk("R4 state", {30'd0, state_o}, {30'd0, m_state});
    chk("R3 int_o", {31'd0, int_o}, {31'd0, exp_int()});
    chk("R5 eint_o", {31'd0, eint_o}, {31'd0, m_eint});
    chk("R9 divert_o", {31'd0, divert_o}, {31'd0, trap});
    chk("R8 pc_load_o", {31'd0, pc_load_o}, {31'd0, load});
    if (load) chk("R7 pc_value_o", pc_value_o, (m_state == 2'd2) ? m_vec : m_epc);
    chk("R6 epc_o", epc_o, m_epc);
    // advance model to the coming edge
    if (m_state == 2'd2 && m_isint) m_pend = 1'b0;
    if (irq && !m_irq_d) m_pend = 1'b1;
    m_irq_d = irq;
    unique case (m_state)
      2'd0: if (trap) begin
        m_hold  = pc;
        m_isint = !ovf && !undef;
        m_vec   = ovf ? V_OVF : V_INT;
        m_state = 2'd1;
      end else if (iret) m_eint = 1'b1;
      2'd1: begin m_epc = m_hold; m_state = 2'd2; end
      default: begin m_eint = 1'b0; m_state = 2'd0; end
    endcase
  endtask

  task automatic idle(logic i_irq);
    step(i_irq, 0, 0, 0, 0, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0417));
    repeat (3) @(negedge clk);
    #1;
    chk("R1 state", {30'd0, state_o}, 32'd0);
    chk("R1 int_o", {31'd0, int_o}, 32'd0);
    chk("R1 eint_o", {31'd0, eint_o}, 32'd1);
    chk("R1 divert_o", {31'd0, divert_o}, 32'd0);
    chk("R1 pc_load_o", {31'd0, pc_load_o}, 32'd0);
    chk("R1 epc_o", epc_o, 32'd0);
    @(negedge clk); rst_ni = 1'b1;

    // interrupt entry
    idle(1);
    chk("R2 int before edge", {31'd0, int_o}, 32'd0);
    idle(1);
    chk("R2 int after edge", {31'd0, int_o}, 32'd1);
    chk("R9 no divert without fetch", {31'd0, divert_o}, 32'd0);
    step(1, 1, 0, 0, 0, 32'h100);
    chk("R4 divert at fetch", {31'd0, divert_o}, 32'd1);
    idle(1);
    chk("R4 save state", {30'd0, state_o}, 32'd1);
    idle(1);
    chk("R5 jump vector", pc_value_o, V_INT);
    chk("R6 epc", epc_o, 32'h100);
    step(1, 1, 0, 0, 0, 32'h104);
    chk("R5 enable dropped", {31'd0, eint_o}, 32'd0);
    chk("R5 int cleared", {31'd0, int_o}, 32'd0);
    step(1, 0, 0, 0, 1, 32'h0);
    chk("R8 iret load", pc_value_o, 32'h100);
    step(1, 1, 0, 0, 0, 32'h100);
    chk("R2 level no retrigger", {31'd0, int_o}, 32'd0);
    chk("R8 enable back", {31'd0, eint_o}, 32'd1);

    // faults
    step(0, 0, 1, 1, 0, 32'h200);
    step(0, 0, 0, 1, 1, 32'h0);
    chk("R9 no divert in save", {31'd0, divert_o}, 32'd0);
    chk("R9 no load in save", {31'd0, pc_load_o}, 32'd0);
    idle(0);
    chk("R7 overflow vector", pc_value_o, V_OVF);
    idle(0);
    chk("R9 dropped inputs", {30'd0, state_o}, 32'd0);
    step(0, 0, 0, 0, 1, 32'h0);
    step(0, 0, 1, 0, 0, 32'h300);
    idle(0);
    idle(0);
    chk("R7 undefined vector", pc_value_o, V_INT);
    step(0, 0, 0, 0, 1, 32'h0);

    // edge during jump
    idle(1);
    idle(0);
    step(0, 1, 0, 0, 0, 32'h400);
    idle(0);
    idle(1);
    chk("R10 jump cycle", {30'd0, state_o}, 32'd2);
    idle(1);
    chk("R3 pending but disabled", {31'd0, int_o}, 32'd0);
    step(1, 0, 0, 0, 1, 32'h0);
    idle(1);
    chk("R10 pending kept", {31'd0, int_o}, 32'd1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic r_irq;
      r_irq = ($urandom_range(7) == 0) ? ~irq : irq;
      step(r_irq, $urandom_range(2) == 0, $urandom_range(39) == 0,
           $urandom_range(39) == 0, $urandom_range(19) == 0,
           {$urandom_range(32'h00FF_FFFF), 2'b00});
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule